// File: doc/BRIEF.md
# Prescaled Down-Counter Timer Pair

This block holds two independent down-counting timers for a small controller. Each timer chains a 6-bit prescaler ahead of an 8-bit counter and raises a one-clock interrupt pulse when both stages run out together. Software sets the timers up through a write-strobed 8-bit register port and reads either counter back at any time without side effects.

Both timers count ticks of an internal time base, which is the system clock divided by four. Timer 0 has no other source. Timer 1 can instead take its count pulses from an external pin. In internal mode that pin can also gate the time base, or start a run in one of two trigger flavours. The pin passes through a two-flop synchronizer before its falling edges are detected.

Each timer has its own control state machine with three states:
- STOP: idle, holding the counter value.
- WAIT: loaded and armed, waiting for a trigger edge. Only trigger modes reach this state.
- RUN: counting.

The named transitions are:
- `load`: a pending load reaches an internal tick. From any state, the timer goes to WAIT in trigger modes and to RUN otherwise.
- `trigger`: a falling edge in WAIT. The timer reloads and goes to RUN.
- `retrigger`: a falling edge in RUN in retriggerable mode. The timer reloads and stays in RUN.
- `expire`: end of count in single-pass mode. The timer goes to WAIT in trigger modes and to STOP otherwise.

In continuous mode, end of count reloads the counter and the timer stays in RUN.

Top module: `tmr_pair`

## Requirements
- R1: After reset both interrupt outputs are low, and the control register, counter 0 and counter 1 all read 0. Timer 1's clock-source bit resets to external.
- R2: Register addresses are: control = 0, prescaler 0 = 1, counter 0 = 2, prescaler 1 = 3, counter 1 = 4. With prescaler field P and counter value N, timer 0 in continuous mode pulses its interrupt every 4·P·N system clocks.
- R3: A prescaler field (bits 7:2 of a prescaler register) of 0 divides by 64.
- R4: A counter initial value of 0 counts 256 prescaler periods.
- R5: Each interrupt pulse lasts exactly one clock. It fires only when the prescaler and the counter reach end of count together.
- R6: Prescaler register bit 0 selects the count mode. When it is 1, the counter reloads and keeps counting. When it is 0, the timer gives one interrupt, then stops with its counter reading 0.
- R7: Control register layout:
  - bit 0: load timer 0
  - bit 1: enable timer 0
  - bit 2: load timer 1
  - bit 3: enable timer 1
  - bits 5:4: pin mode (00 clock, 01 gate, 10 trigger, 11 retriggerable trigger)
  - bits 7:6: reserved

  Load bits copy both initial values into the timer on the next internal tick, and they read back as 0. Bits 7:6 read back as 0.
- R8: While a timer's enable bit is 0, its counter holds its value and it raises no interrupt.
- R9: When prescaler 1 bit 1 is 0 (external source), each synchronized falling edge on the pin is one count pulse for timer 1, whatever the pin mode.
- R10: When timer 1 uses the internal source in gate mode, it counts internal ticks only while the pin is high.
- R11: In non-retriggerable trigger mode, a load arms timer 1 without counting. A falling edge starts a run, and edges during that run are ignored.
- R12: In retriggerable trigger mode, a falling edge during a run reloads timer 1, which delays its interrupt.
- R13: Reading a counter address returns that counter's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| ext_pin | input | 1 | External timer-1 input pin |
| irq_t0 | output | 1 | Timer 0 end-of-count pulse |
| irq_t1 | output | 1 | Timer 1 end-of-count pulse |

## Verification
A fault in the prescaler or counter reload would show at the ports as an interrupt period different from 4·P·N, within one period of the load. A state machine stuck in the wrong state shows up in two ways: an interrupt that never comes, or an interrupt during a window where the pin mode forbids one. The bench therefore counts interrupt pulses across timed edge trains. Counter read-back exposes a wrong count step within a few cycles of each pin edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 6;
    localparam int CNT_W  = 8;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_PRE0 = 3'd1;
    localparam logic [2:0] A_CNT0 = 3'd2;
    localparam logic [2:0] A_PRE1 = 3'd3;
    localparam logic [2:0] A_CNT1 = 3'd4;

    typedef enum logic [1:0] {
        PIN_CLOCK  = 2'b00,
        PIN_GATE   = 2'b01,
        PIN_TRIG   = 2'b10,
        PIN_RETRIG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    generate
        if (DIV > 1) begin : g_chk
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], pin};
    end

    assign level = shreg[STAGES-1];
    assign fall  = shreg[STAGES] & ~shreg[STAGES-1];

    // R9
    fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter bit HAS_PIN   = 1'b0,
    parameter int PRE_WIDTH = PRE_W,
    parameter int CNT_WIDTH = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load_wr,
    input  logic                 enable,
    input  logic                 cont,
    input  logic                 src_int,
    input  pin_mode_e            pin_mode,
    input  logic                 pin_level,
    input  logic                 pin_fall,
    input  logic [PRE_WIDTH-1:0] init_pre,
    input  logic [CNT_WIDTH-1:0] init_cnt,
    output logic [CNT_WIDTH-1:0] cnt_cur,
    output logic                 irq
);
    run_state_e state, state_nx;
    logic [PRE_WIDTH-1:0] pre_cur;
    logic load_pend, load_fire;
    logic trig_mode, retrig, cnt_pulse;
    logic trig_start, retrig_hit, step, pre_end, cnt_end, end_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) load_pend <= 1'b0;
        else        load_pend <= (load_pend & ~tick) | load_wr;
    end
    assign load_fire = load_pend & tick;

    generate
        if (HAS_PIN) begin : g_pin
            assign trig_mode = src_int && (pin_mode == PIN_TRIG || pin_mode == PIN_RETRIG);
            assign retrig    = src_int && (pin_mode == PIN_RETRIG);
            assign cnt_pulse = enable & (src_int ? (tick & (pin_mode != PIN_GATE || pin_level))
                                                 : pin_fall);
        end else begin : g_int
            logic unused_pin;
            assign unused_pin = &{1'b0, src_int, pin_mode, pin_level};
            assign trig_mode  = 1'b0;
            assign retrig     = 1'b0;
            assign cnt_pulse  = enable & tick;
        end
    endgenerate

    assign trig_start = trig_mode & enable & pin_fall & (state == ST_WAIT);
    assign retrig_hit = retrig & enable & pin_fall & (state == ST_RUN);
    assign step       = (state == ST_RUN) & cnt_pulse & ~retrig_hit & ~load_fire;
    assign pre_end    = (pre_cur == PRE_WIDTH'(1));
    assign cnt_end    = (cnt_cur == CNT_WIDTH'(1));
    assign end_hit    = step & pre_end & cnt_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOP: if (load_fire) state_nx = trig_mode ? ST_WAIT : ST_RUN;
            ST_WAIT: begin
                if (load_fire)       state_nx = trig_mode ? ST_WAIT : ST_RUN;
                else if (trig_start) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (load_fire)               state_nx = trig_mode ? ST_WAIT : ST_RUN;
                else if (end_hit && !cont)   state_nx = trig_mode ? ST_WAIT : ST_STOP;
            end
            default: state_nx = ST_STOP;
        endcase
    end

    // output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cur <= '0;
            cnt_cur <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= end_hit;
            if (load_fire || trig_start || retrig_hit) begin
                pre_cur <= init_pre;
                cnt_cur <= init_cnt;
            end else if (step) begin
                if (pre_end) begin
                    pre_cur <= init_pre;
                    if (cnt_end) cnt_cur <= cont ? init_cnt : '0;
                    else         cnt_cur <= cnt_cur - 1'b1;
                end else begin
                    pre_cur <= pre_cur - 1'b1;
                end
            end
        end
    end

    // R5
    irq_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(state) == ST_RUN));
    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cont)) |-> (state != ST_RUN));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(load_fire)) |-> $stable(cnt_cur));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_pin,
    output logic              irq_t0,
    output logic              irq_t1
);
    localparam int NUM_T = 2;

    logic                        tick, pin_level, pin_fall;
    logic [NUM_T-1:0]            en, cont, load_wr, irq;
    logic                        src1_int;
    pin_mode_e                   pin_mode;
    logic [NUM_T-1:0][PRE_W-1:0] pre_init;
    logic [NUM_T-1:0][CNT_W-1:0] cnt_init, cnt_cur;

    tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .level(pin_level), .fall(pin_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= '0;
            cont     <= '0;
            src1_int <= 1'b0;
            pin_mode <= PIN_CLOCK;
            pre_init <= '0;
            cnt_init <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE: begin
                    en[0]    <= wr_data[1];
                    en[1]    <= wr_data[3];
                    pin_mode <= pin_mode_e'(wr_data[5:4]);
                end
                A_PRE0: begin
                    pre_init[0] <= wr_data[7:2];
                    cont[0]     <= wr_data[0];
                end
                A_PRE1: begin
                    pre_init[1] <= wr_data[7:2];
                    src1_int    <= wr_data[1];
                    cont[1]     <= wr_data[0];
                end
                A_CNT0:  cnt_init[0] <= wr_data;
                A_CNT1:  cnt_init[1] <= wr_data;
                default: ;
            endcase
        end
    end

    assign load_wr[0] = wr_en && (wr_addr == A_MODE) && wr_data[0];
    assign load_wr[1] = wr_en && (wr_addr == A_MODE) && wr_data[2];

    generate
        for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
            tmr_unit #(.HAS_PIN(i == 1)) u_unit (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .load_wr  (load_wr[i]),
                .enable   (en[i]),
                .cont     (cont[i]),
                .src_int  ((i == 1) ? src1_int : 1'b1),
                .pin_mode (pin_mode),
                .pin_level(pin_level),
                .pin_fall (pin_fall),
                .init_pre (pre_init[i]),
                .init_cnt (cnt_init[i]),
                .cnt_cur  (cnt_cur[i]),
                .irq      (irq[i])
            );
        end
    endgenerate

    assign irq_t0 = irq[0];
    assign irq_t1 = irq[1];

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = {2'b00, pin_mode, en[1], 1'b0, en[0], 1'b0};
            A_CNT0:  rd_data = cnt_cur[0];
            A_CNT1:  rd_data = cnt_cur[1];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_pin = 1'b1;
    logic       irq_t0, irq_t1;

    int total = 0;
    int bad = 0;
    int n_irq0 = 0;
    int n_irq1 = 0;

    // prescaler, count, expected period in clocks
    localparam int VEC [6][3] = '{
        '{1, 1, 4}, '{1, 5, 20}, '{3, 2, 24},
        '{0, 1, 256}, '{1, 0, 1024}, '{2, 7, 56}
    };

    tmr_pair u_tmr_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_pin(ext_pin),
        .irq_t0(irq_t0), .irq_t1(irq_t1)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (irq_t0) n_irq0++;
        if (irq_t1) n_irq1++;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(input int which, output int p);
        int t = 0;
        while (((which == 0) ? irq_t0 : irq_t1) == 1'b0 && t < 5000) begin
            @(negedge clk); t++;
        end
        @(negedge clk);
        p = 1;
        while (((which == 0) ? irq_t0 : irq_t1) == 1'b0 && p < 5000) begin
            @(negedge clk); p++;
        end
    endtask

    task automatic pin_pulse();
        ext_pin = 1'b0; idle(3);
        ext_pin = 1'b1; idle(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, v2, p, base;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 irq_t0", int'(irq_t0), 0);
        check("R1 irq_t1", int'(irq_t1), 0);
        rd(3'd0, v); check("R1 control", v, 0);
        rd(3'd2, v); check("R1 counter0", v, 0);
        rd(3'd4, v); check("R1 counter1", v, 0);

        // R2 / R3 / R4 period table, timer 0 continuous
        for (int i = 0; i < 6; i++) begin
            wr(3'd1, 8'((VEC[i][0] << 2) | 1));
            wr(3'd2, 8'(VEC[i][1]));
            wr(3'd0, 8'h03);
            idle(8);
            period(0, p);
            check((VEC[i][0] == 0) ? "R3 period" : (VEC[i][1] == 0) ? "R4 period" : "R2 period",
                  p, VEC[i][2]);
            if (i == 0) begin
                @(negedge clk);
                check("R5 pulse width", int'(irq_t0), 0);
            end
        end

        // R7 load bits read 0, reserved bits ignored
        rd(3'd0, v); check("R7 control readback", v, 2);
        wr(3'd0, 8'hC2);
        rd(3'd0, v); check("R7 reserved bits", v, 2);

        // R8 hold while disabled; R7 load with enable off
        wr(3'd0, 8'h00);
        wr(3'd2, 8'd9);
        wr(3'd0, 8'h01);
        idle(6);
        rd(3'd2, v); check("R7 load copies", v, 9);
        base = n_irq0;
        idle(100);
        rd(3'd2, v2); check("R8 counter held", v2, 9);
        check("R8 no irq", n_irq0 - base, 0);

        // R6 single pass
        wr(3'd1, 8'h04);
        wr(3'd2, 8'd3);
        base = n_irq0;
        wr(3'd0, 8'h03);
        idle(100);
        check("R6 single irq", n_irq0 - base, 1);
        rd(3'd2, v); check("R6 stops at zero", v, 0);

        // R9 external clock, R13 readback
        wr(3'd3, 8'h04);
        wr(3'd4, 8'd3);
        wr(3'd0, 8'h0C);
        idle(8);
        rd(3'd4, v); check("R13 counter1 readback", v, 3);
        base = n_irq1;
        pin_pulse();
        rd(3'd4, v); check("R9 one edge one count", v, 2);
        pin_pulse();
        pin_pulse();
        check("R9 irq after three edges", n_irq1 - base, 1);
        rd(3'd4, v); check("R9 counter zero", v, 0);

        // R10 gate
        ext_pin = 1'b0;
        wr(3'd3, 8'h07);
        wr(3'd4, 8'd4);
        wr(3'd0, 8'h1C);
        idle(8);
        base = n_irq1;
        idle(100);
        check("R10 gated no irq", n_irq1 - base, 0);
        rd(3'd4, v); check("R10 gated hold", v, 4);
        ext_pin = 1'b1;
        period(1, p);
        check("R10 gate open period", p, 16);

        // R11 non-retriggerable trigger
        wr(3'd3, 8'h06);
        wr(3'd4, 8'd10);
        wr(3'd0, 8'h2C);
        idle(8);
        base = n_irq1;
        idle(100);
        check("R11 armed no irq", n_irq1 - base, 0);
        pin_pulse(); pin_pulse(); pin_pulse(); idle(15);
        check("R11 edges ignored", n_irq1 - base, 1);
        idle(100);
        check("R11 single run", n_irq1 - base, 1);

        // R12 retriggerable trigger
        wr(3'd0, 8'h3C);
        idle(20);
        base = n_irq1;
        pin_pulse(); pin_pulse(); pin_pulse(); idle(15);
        check("R12 retrigger delays", n_irq1 - base, 0);
        idle(60);
        check("R12 fires after last edge", n_irq1 - base, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule